// File: doc/BRIEF.md
# Display Sequencer Character Clock Generator

This block is the clock-mode section of a text/graphics display sequencer. The host programs one control byte through an indexed pair of byte I/O ports: the host first writes a register number to the index port, then reads or writes that register at the data port. From a free-running dot clock enable, the block derives a pixel strobe, a character strobe, a serializer load strobe, and a blank / fetch-disable pair.

The control byte selects several things. It sets the character width to 8 or 9 dots, and it can halve the dot rate, which stretches every timing period. It sets how often the serializer is reloaded: every character, every second character or every fourth character. Finally, it can turn the screen off. Screen-off suppresses pixels and memory fetch, but the character cadence that drives sync timing keeps running. Width, halving and load settings are held in an active copy that takes a new value only on a character boundary.

Top module: `vga_charclk_gen`

## Requirements
- R1: A write to address 0x3C4 sets the index. A write to 0x3C5 while the index equals 0x01 updates the control byte, and a data write under any other index leaves it unchanged. A read of 0x3C5 with index 0x01 returns the control byte, and a read of 0x3C4 returns the index.
- R2: The control byte and the index reset to 0. Bits 7, 6 and 1 of the control byte are reserved: they read as 0 and writes to them are ignored.
- R3: Bit 0 selects the character width. A value of 0 gives 9 dot strobes per character and a value of 1 gives 8. `char_stb` is a one-cycle pulse on the last dot of each character.
- R4: Bit 3 set to 1 makes `dot_stb` assert on every second `dot_ce_in`, so a character lasts twice as many enables. Bit 3 set to 0 passes each enable through as a dot.
- R5: Bit 4 set to 1 loads the serializer every 4 characters, and bit 4 overrides bit 2. When bit 4 is 0, bit 2 set to 1 loads every 2 characters and bit 2 set to 0 loads every character.
- R6: `load_stb` only asserts together with `char_stb`, and `char_stb` only asserts together with `dot_stb`. `dot_stb` only asserts together with `dot_ce_in`.
- R7: A width, halving or load setting written in the middle of a character takes effect from the next character. The character in progress keeps its old width.
- R8: Bit 5 set to 1 drives `blank` and `fetch_dis` high from the cycle after the write. The character and load cadence is left unchanged while bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (0 when not reading) |
| dot_ce_in | input | 1 | Free-running dot clock enable |
| dot_stb | output | 1 | Pixel strobe |
| char_stb | output | 1 | Last dot of a character |
| load_stb | output | 1 | Serializer load strobe |
| blank | output | 1 | Pixel output suppressed |
| fetch_dis | output | 1 | Display memory fetch disabled |

## Verification
The bench builds the block with its default parameters: 16-bit addresses at 0x3C4/0x3C5, control index 0x01 and a 4-bit dot counter. With these values every combination of width and halving is in reach, giving 8, 9, 16 and 18 enables per character, and so is every load grouping, including the case where both load bits are set. The bench also reaches mid-character rewrites and a screen-off setting that runs alongside the character cadence.

// File: rtl/vga_sq_pkg.sv
package vga_sq_pkg;

    typedef struct packed {
        logic scr_off;
        logic load4;
        logic halve;
        logic load2;
        logic narrow;
    } clkmode_t;

    localparam int unsigned BYTE_W = 8;

    function automatic logic [BYTE_W-1:0] mode_to_byte(input clkmode_t m);
        return {2'b00, m.scr_off, m.load4, m.halve, m.load2, 1'b0, m.narrow};
    endfunction

    function automatic clkmode_t byte_to_mode(input logic [BYTE_W-1:0] b);
        clkmode_t m;
        m.narrow  = b[0];
        m.load2   = b[2];
        m.halve   = b[3];
        m.load4   = b[4];
        m.scr_off = b[5];
        return m;
    endfunction

    function automatic logic [1:0] group_last(input clkmode_t m);
        if (m.load4)      return 2'd3;
        else if (m.load2) return 2'd1;
        else              return 2'd0;
    endfunction

endpackage

// File: rtl/vga_sq_regs.sv
module vga_sq_regs
    import vga_sq_pkg::*;
#(
    parameter int unsigned    ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h03C4,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h03C5,
    parameter logic [7:0]     MODE_IDX = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [7:0]        idx_o,
    output clkmode_t          mode_o
);
    logic [7:0] idx_q;
    clkmode_t   mode_q;
    logic       hit_mode;

    assign hit_mode = (io_addr == DAT_ADDR) && (idx_q == MODE_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            mode_q <= '0;
        end else if (io_wr) begin
            if (io_addr == IDX_ADDR) idx_q <= io_wdata;
            else if (hit_mode)       mode_q <= byte_to_mode(io_wdata);
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (io_addr == IDX_ADDR) io_rdata = idx_q;
            else if (hit_mode)       io_rdata = mode_to_byte(mode_q);
        end
    end

    assign idx_o  = idx_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/vga_sq_dotgen.sv
module vga_sq_dotgen #(
    parameter int unsigned CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic dot_ce_in,
    input  logic halve,
    input  logic narrow,
    output logic dot_stb,
    output logic char_stb
);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(8);

    logic             div_ph;
    logic [CNT_W-1:0] dcnt;
    logic [CNT_W-1:0] dlast;

    assign dlast    = narrow ? LAST_NARROW : LAST_WIDE;
    assign dot_stb  = dot_ce_in && (!halve || div_ph);
    assign char_stb = dot_stb && (dcnt >= dlast);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_ph <= 1'b0;
            dcnt   <= '0;
        end else begin
            if (char_stb || !halve) div_ph <= 1'b0;
            else if (dot_ce_in)     div_ph <= !div_ph;
            if (char_stb)           dcnt <= '0;
            else if (dot_stb)       dcnt <= dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/vga_sq_loadgrp.sv
module vga_sq_loadgrp #(
    parameter int unsigned GRP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             char_stb,
    input  logic [GRP_W-1:0] grp_last,
    output logic             load_stb
);
    logic [GRP_W-1:0] gcnt;

    assign load_stb = char_stb && (gcnt >= grp_last);

    always_ff @(posedge clk) begin
        if (rst)           gcnt <= '0;
        else if (load_stb) gcnt <= '0;
        else if (char_stb) gcnt <= gcnt + 1'b1;
    end
endmodule

// File: rtl/vga_charclk_gen.sv
module vga_charclk_gen
    import vga_sq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h03C4,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h03C5,
    parameter logic [7:0]        MODE_IDX = 8'h01,
    parameter int unsigned       CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              dot_ce_in,
    output logic              dot_stb,
    output logic              char_stb,
    output logic              load_stb,
    output logic              blank,
    output logic              fetch_dis
);
    localparam int unsigned GRP_W = 2;

    clkmode_t   mode_reg;
    clkmode_t   mode_act;
    logic [7:0] idx_q;

    vga_sq_regs #(
        .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR), .MODE_IDX(MODE_IDX)
    ) u_regs (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .idx_o(idx_q), .mode_o(mode_reg)
    );

    always_ff @(posedge clk) begin
        if (rst)           mode_act <= '0;
        else if (char_stb) mode_act <= mode_reg;
    end

    vga_sq_dotgen #(.CNT_W(CNT_W)) u_dot (
        .clk(clk), .rst(rst), .dot_ce_in(dot_ce_in), .halve(mode_act.halve),
        .narrow(mode_act.narrow), .dot_stb(dot_stb), .char_stb(char_stb)
    );

    vga_sq_loadgrp #(.GRP_W(GRP_W)) u_grp (
        .clk(clk), .rst(rst), .char_stb(char_stb),
        .grp_last(group_last(mode_act)), .load_stb(load_stb)
    );

    assign blank     = mode_reg.scr_off;
    assign fetch_dis = mode_reg.scr_off;
endmodule

// File: rtl/vga_charclk_chk.sv
module vga_charclk_chk #(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h03C5,
    parameter logic [7:0]        MODE_IDX = 8'h01
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_rdata,
    input logic [7:0]        idx,
    input logic              dot_ce_in,
    input logic              dot_stb,
    input logic              char_stb,
    input logic              load_stb,
    input logic              blank
);
    AST_LOAD_ON_CHAR: assert property (@(posedge clk) disable iff (rst) load_stb |-> char_stb); // R6
    AST_CHAR_ON_DOT:  assert property (@(posedge clk) disable iff (rst) char_stb |-> dot_stb);  // R6
    AST_DOT_NEEDS_CE: assert property (@(posedge clk) disable iff (rst) dot_stb |-> dot_ce_in); // R4
    AST_CHAR_SINGLE:  assert property (@(posedge clk) disable iff (rst) char_stb |=> !char_stb); // R3
    AST_RSVD_ZERO:    assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == DAT_ADDR && idx == MODE_IDX) |-> (io_rdata[7:6] == 2'b00 && !io_rdata[1])); // R2
    AST_BLANK_BY_WRITE: assert property (@(posedge clk) disable iff (rst) $rose(blank) |-> $past(io_wr)); // R8
endmodule

bind vga_charclk_gen vga_charclk_chk #(.ADDR_W(ADDR_W), .DAT_ADDR(DAT_ADDR), .MODE_IDX(MODE_IDX)) u_chk (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_rdata(io_rdata),
    .idx(idx_q), .dot_ce_in(dot_ce_in), .dot_stb(dot_stb), .char_stb(char_stb),
    .load_stb(load_stb), .blank(blank)
);

// File: tb/vga_charclk_gen_tb.sv
module vga_charclk_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_IDX = 16'h03C4;
    localparam logic [15:0] A_DAT = 16'h03C5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic dot_ce_in = 1'b0;
    logic dot_stb, char_stb, load_stb, blank, fetch_dis;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vga_charclk_gen u_dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dot_ce_in(dot_ce_in),
        .dot_stb(dot_stb), .char_stb(char_stb), .load_stb(load_stb),
        .blank(blank), .fetch_dis(fetch_dis)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] v);
        wr(A_IDX, 8'h01);
        wr(A_DAT, v);
    endtask

    // Runs with dot_ce_in high every cycle; returns enables per character,
    // dots per character and characters per load group once settled.
    task automatic measure(output int cyc, output int dots, output int cpl);
        int st = 0, c = 0, d = 0, ch = 0;
        cyc = -1; dots = -1; cpl = -1;
        dot_ce_in = 1'b1;
        for (int i = 0; i < 600 && st < 3; i++) begin
            @(negedge clk);
            if (st == 0 && char_stb) st = 1;
            else if (st == 1 && load_stb) begin st = 2; c = 0; d = 0; ch = 0; end
            else if (st == 2) begin
                c++;
                if (dot_stb) d++;
                if (char_stb) begin
                    ch++;
                    if (ch == 1) begin cyc = c; dots = d; end
                end
                if (load_stb) begin cpl = ch; st = 3; end
            end
        end
        dot_ce_in = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        @(negedge clk);
        check("R2 dot_stb idle", dot_stb, 0);
        check("R2 blank at reset", blank, 0);
        rd(A_IDX, v); check("R2 index reset", v, 0);
        wr(A_IDX, 8'h01);
        rd(A_DAT, v); check("R2 mode reset", v, 0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        set_mode(8'hFF);
        rd(A_DAT, v); check("R2 reserved bits read 0", v, 8'h3D);
        rd(A_IDX, v); check("R1 index readback", v, 8'h01);
        wr(A_IDX, 8'h02); wr(A_DAT, 8'h00);
        wr(A_IDX, 8'h01);
        rd(A_DAT, v); check("R1 other index write ignored", v, 8'h3D);
        set_mode(8'h00);
        rd(A_DAT, v); check("R1 mode rewrite", v, 8'h00);
    endtask

    task automatic t_mode(input logic [7:0] m, input int ecyc, input int edots, input int ecpl, input string tag);
        int cyc, dots, cpl;
        set_mode(m);
        measure(cyc, dots, cpl);
        check({tag, " enables per char"}, cyc, ecyc);
        check({tag, " dots per char"}, dots, edots);
        check({tag, " chars per load"}, cpl, ecpl);
    endtask

    task automatic t_midchar;
        int d = 0, first = -1, second = -1, seen = 0, st = 0;
        set_mode(8'h00);
        dot_ce_in = 1'b1;
        for (int i = 0; i < 200 && seen < 2; i++) begin
            @(negedge clk);
            io_wr = 1'b0;
            if (st == 0) begin
                if (char_stb) begin st = 1; d = 0; end
            end else begin
                if (dot_stb) d++;
                if (d == 3 && st == 1) begin
                    io_wr = 1'b1; io_addr = A_DAT; io_wdata = 8'h01; st = 2;
                end
                if (char_stb) begin
                    if (seen == 0) first = d; else second = d;
                    seen++; d = 0;
                end
            end
        end
        io_wr = 1'b0;
        dot_ce_in = 1'b0;
        check("R7 current char keeps 9 dots", first, 9);
        check("R7 next char uses 8 dots", second, 8);
    endtask

    task automatic t_screen_off;
        int cyc, dots, cpl;
        set_mode(8'h20);
        @(negedge clk);
        check("R8 blank high", blank, 1);
        check("R8 fetch_dis high", fetch_dis, 1);
        measure(cyc, dots, cpl);
        check("R8 char cadence kept", cyc, 9);
        check("R8 load cadence kept", cpl, 1);
        set_mode(8'h00);
        @(negedge clk);
        check("R8 blank released", blank, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_mode(8'h00, 9, 9, 1, "R3 width9");
        t_mode(8'h01, 8, 8, 1, "R3 width8");
        t_mode(8'h09, 16, 8, 1, "R4 halve width8");
        t_mode(8'h08, 18, 9, 1, "R4 halve width9");
        t_mode(8'h04, 9, 9, 2, "R5 load2");
        t_mode(8'h10, 9, 9, 4, "R5 load4");
        t_mode(8'h15, 8, 8, 4, "R5 load4 overrides load2");
        t_mode(8'h0C, 18, 9, 2, "R6 load2 with halve");
        t_midchar();
        t_screen_off();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule